// File: doc/BRIEF.md
# Big-Endian Sub-Word Data Memory

This block is a word-organised data store whose words are eight bytes wide. A single request port carries loads and stores of one, two, four or eight bytes. Inside each word, the byte with the lowest address sits in the most significant position. A narrow store reads the word it targets, replaces only the addressed bytes and writes the result back, so the other bytes keep their values. A narrow load takes the addressed bytes out of the word and places them at the bottom of the result.

An access whose byte offset is not a whole multiple of its size is refused. The block raises an error flag and leaves the contents alone. Every word carries a written flag that reset clears, so a location that has never been stored to reads back as zero. The depth in words is a parameter and must be a power of two.

Top module: `bwm_top`

## Requirements
- R1: An 8-byte store (size code 3) replaces the whole addressed word. A following 8-byte load returns exactly the stored value.
- R2: Bytes are big-endian within a word. The byte at offset 0 occupies bits 63:56, and the byte at offset 7 occupies bits 7:0. A lane of n bytes at offset k sits at a shift of (8 − n − k) × 8 bits.
- R3: A store of 1, 2 or 4 bytes writes only the addressed lane and takes its data from the low n bytes of wrData. All other bytes of the word keep their previous values.
- R4: A load of 1, 2 or 4 bytes returns the lane right-justified at bit 0, with every bit above the lane zero.
- R5: A request whose offset is not a multiple of its size sets errFlag high for exactly the cycle after the request. That request changes no memory byte and does not raise rdValid.
- R6: Any location that has not been stored to since the last reset reads as zero.
- R7: Load results appear on rdData with rdValid high in the cycle after the request. rdData holds its value after stores, errors and idle cycles. rdValid is never high for a store.
- R8: The size code maps 0, 1, 2, 3 to 1, 2, 4, 8 bytes. The word index is byteAddr shifted right by 3, and the offset is byteAddr[2:0].
- R9: While reqValid is low, nothing in the memory or on the outputs changes, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | A request is present this cycle |
| wrEn | input | 1 | 1 = store, 0 = load |
| byteAddr | input | log2(DEPTH)+3 | Byte address of the access |
| sizeCode | input | 2 | Access size code (0:1, 1:2, 2:4, 3:8 bytes) |
| wrData | input | 64 | Store data, right-justified |
| rdData | output | 64 | Registered load result, right-justified |
| rdValid | output | 1 | rdData carries a fresh load result |
| errFlag | output | 1 | The previous request was misaligned |

## Verification
A request takes effect at the rising edge where it is presented. A store is visible to any request made in the next cycle. Load data, rdValid and errFlag are all due one edge after the request. The bench drives and samples on the falling edge. Its byte-array model produces the expected values for the request just driven, and the bench compares all three outputs at the next falling edge, every cycle, including idle and reset cycles.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

  localparam int unsigned WORD_BYTES = 8;
  localparam int unsigned WORD_BITS  = WORD_BYTES * 8;
  localparam int unsigned OFF_W      = $clog2(WORD_BYTES);

  typedef logic [1:0]       sizeCode_t;
  typedef logic [OFF_W-1:0] offset_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic      doWrite;
    logic      doRead;
    offset_t   offset;
    sizeCode_t sizeCode;
  } strobe_t;

  // index of the last byte in a lane, relative to its first byte
  function automatic offset_t laneLast(input sizeCode_t code);
    case (code)
      2'd0:    return offset_t'(0);
      2'd1:    return offset_t'(1);
      2'd2:    return offset_t'(3);
      default: return offset_t'(7);
    endcase
  endfunction

  function automatic logic [WORD_BITS-1:0] laneMaskOf(input sizeCode_t code);
    case (code)
      2'd0:    return WORD_BITS'(64'h0000_0000_0000_00FF);
      2'd1:    return WORD_BITS'(64'h0000_0000_0000_FFFF);
      2'd2:    return WORD_BITS'(64'h0000_0000_FFFF_FFFF);
      default: return '1;
    endcase
  endfunction

endpackage

// File: rtl/bwm_ctrl.sv
module bwm_ctrl
  import bwm_pkg::*;
#(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned ADDR_W = IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] byteAddr,
  input  sizeCode_t         sizeCode,
  output strobe_t           strobes,
  output logic [IDX_W-1:0]  wordIdx,
  output logic              rdValid,
  output logic              errFlag
);

  offset_t offset;
  logic    aligned;

  assign offset  = byteAddr[OFF_W-1:0];
  assign wordIdx = byteAddr[ADDR_W-1:OFF_W];
  // aligned when the offset has no bits inside the lane span
  assign aligned = ((offset & laneLast(sizeCode)) == '0);

  always_comb begin
    strobes          = '0;
    strobes.offset   = offset;
    strobes.sizeCode = sizeCode;
    strobes.doWrite  = reqValid && wrEn && aligned;
    strobes.doRead   = reqValid && !wrEn && aligned;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      rdValid <= reqValid && !wrEn && aligned;
      errFlag <= reqValid && !aligned;
    end
  end

  // R5
  misalign_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !aligned) |=> (errFlag && !rdValid));

  // R5
  err_has_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> $past(reqValid));

  // R7
  no_store_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && wrEn) |=> !rdValid);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rdValid && !errFlag));

endmodule

// File: rtl/bwm_datapath.sv
module bwm_datapath
  import bwm_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobes,
  input  logic [IDX_W-1:0]     wordIdx,
  input  logic [WORD_BITS-1:0] wrData,
  output logic [WORD_BITS-1:0] rdData
);

  logic [WORD_BITS-1:0] wordQ [DEPTH];
  logic [DEPTH-1:0]     validQ;
  logic [WORD_BITS-1:0] curWord;
  logic [WORD_BITS-1:0] laneMask;
  logic [WORD_BITS-1:0] mergedWord;
  logic [5:0]           shAmt;
  offset_t              byteShift;

  // per-word storage with a written flag
  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic                 hit;
    logic                 validBit;
    logic [WORD_BITS-1:0] wordReg;

    assign hit = strobes.doWrite && (wordIdx == IDX_W'(w));

    always_ff @(posedge clk) begin
      if (hit) wordReg <= mergedWord;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)    validBit <= 1'b0;
      else if (hit) validBit <= 1'b1;
    end

    assign validQ[w] = validBit;
    assign wordQ[w]  = wordReg;
  end

  // unwritten words read as zero
  assign curWord = validQ[wordIdx] ? wordQ[wordIdx] : '0;

  // big-endian lane placement: lane end counted from the low byte
  assign byteShift = offset_t'(WORD_BYTES - 1) - strobes.offset - laneLast(strobes.sizeCode);
  assign shAmt     = {byteShift, 3'b000};
  assign laneMask  = laneMaskOf(strobes.sizeCode);

  always_comb begin
    if (strobes.sizeCode == 2'd3)
      mergedWord = wrData;
    else
      mergedWord = (curWord & ~(laneMask << shAmt)) | ((wrData & laneMask) << shAmt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rdData <= '0;
    else if (strobes.doRead) rdData <= (curWord >> shAmt) & laneMask;
  end

  // R4
  byte_load_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doRead && strobes.sizeCode == 2'd0) |=> (rdData[WORD_BITS-1:8] == '0));

  // R4
  half_load_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doRead && strobes.sizeCode == 2'd1) |=> (rdData[WORD_BITS-1:16] == '0));

  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.doRead |=> $stable(rdData));

  // R6
  written_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.doWrite |=> $stable(validQ));

  // R1
  full_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doWrite && strobes.sizeCode == 2'd3) |=> (wordQ[$past(wordIdx)] == $past(wrData)));

endmodule

// File: rtl/bwm_top.sv
module bwm_top
  import bwm_pkg::*;
#(
  parameter  int unsigned DEPTH  = 16,
  localparam int unsigned IDX_W  = $clog2(DEPTH),
  localparam int unsigned ADDR_W = IDX_W + OFF_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    byteAddr,
  input  logic [1:0]           sizeCode,
  input  logic [WORD_BITS-1:0] wrData,
  output logic [WORD_BITS-1:0] rdData,
  output logic                 rdValid,
  output logic                 errFlag
);

  strobe_t          strobes;
  logic [IDX_W-1:0] wordIdx;

  bwm_ctrl #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .wrEn     (wrEn),
    .byteAddr (byteAddr),
    .sizeCode (sizeCode),
    .strobes  (strobes),
    .wordIdx  (wordIdx),
    .rdValid  (rdValid),
    .errFlag  (errFlag)
  );

  bwm_datapath #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wordIdx (wordIdx),
    .wrData  (wrData),
    .rdData  (rdData)
  );

endmodule

// File: tb/bwm_top_test.sv
module bwm_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int ADDR_W     = $clog2(DEPTH) + 3;
  localparam int NBYTES     = DEPTH * 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] byteAddr = '0;
  logic [1:0]        sizeCode = '0;
  logic [63:0]       wrData = '0;
  logic [63:0]       rdData;
  logic              rdValid;
  logic              errFlag;

  int checks = 0;
  int fails  = 0;

  logic [7:0]  refMem [NBYTES];
  logic [63:0] expData = '0;
  logic        expValid = 1'b0;
  logic        expErr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bwm_top #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .wrEn(wrEn),
    .byteAddr(byteAddr), .sizeCode(sizeCode), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid), .errFlag(errFlag)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    check({tag, " rdValid"}, {63'd0, rdValid}, {63'd0, expValid});
    check({tag, " errFlag"}, {63'd0, errFlag}, {63'd0, expErr});
    check({tag, " rdData"}, rdData, expData);
  endtask

  // one request per cycle; model evaluated from byte-level semantics
  task automatic step(input string tag, input logic v, input logic w,
                      input int addr, input int code, input logic [63:0] wd);
    int n;
    logic [63:0] acc;
    n = 1 << code;
    reqValid = v; wrEn = w; byteAddr = ADDR_W'(addr); sizeCode = 2'(code); wrData = wd;
    expValid = 1'b0;
    expErr   = 1'b0;
    if (v) begin
      if ((addr % n) != 0) begin
        expErr = 1'b1;
      end else if (w) begin
        for (int i = 0; i < n; i++)
          refMem[addr + i] = 8'(wd >> ((n - 1 - i) * 8));
      end else begin
        acc = '0;
        for (int i = 0; i < n; i++)
          acc = (acc << 8) | {56'd0, refMem[addr + i]};
        expData  = acc;
        expValid = 1'b1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, 1'b0, 0, 0, 64'd0);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    reqValid = 1'b0;
    for (int i = 0; i < NBYTES; i++) refMem[i] = 8'd0;
    expData = '0; expValid = 1'b0; expErr = 1'b0;
    repeat (2) @(negedge clk);
    compareAll("R6 reset");
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R7 after reset");
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    @(negedge clk);
    doReset();

    // R6: never-written word reads zero
    step("R6 unwritten load", 1, 0, 0, 3, 64'd0);
    // R1, R8: full store to word 1, full load back
    step("R1 full store", 1, 1, 8, 3, 64'h0123_4567_89AB_CDEF);
    step("R1 full load", 1, 0, 8, 3, 64'd0);
    // R2, R4: narrow loads pick big-endian lanes
    step("R2 byte off0", 1, 0, 8, 0, 64'd0);
    step("R2 byte off7", 1, 0, 15, 0, 64'd0);
    step("R2 half off2", 1, 0, 10, 1, 64'd0);
    step("R4 word off4", 1, 0, 12, 2, 64'd0);
    // R3: narrow stores keep neighbour bytes, use low data bytes
    step("R3 byte store", 1, 1, 9, 0, 64'hFFFF_FFFF_FFFF_FF5A);
    step("R3 half store", 1, 1, 14, 1, 64'hAAAA_AAAA_AAAA_1122);
    step("R3 word store", 1, 1, 16, 2, 64'hDEAD_BEEF);
    step("R3 readback w1", 1, 0, 8, 3, 64'd0);
    step("R3 readback w2", 1, 0, 16, 3, 64'd0);
    // R5: misaligned store and load rejected
    step("R5 misaligned store", 1, 1, 10, 2, 64'h5555_5555_5555_5555);
    step("R5 misaligned load", 1, 0, 3, 1, 64'd0);
    step("R5 misaligned full", 1, 0, 12, 3, 64'd0);
    step("R5 unchanged", 1, 0, 8, 3, 64'd0);
    // R9: no request does nothing even with write enable
    step("R9 idle write", 0, 1, 8, 3, 64'hFFFF_FFFF_FFFF_FFFF);
    step("R9 unchanged", 1, 0, 8, 3, 64'd0);
    // R7: rdData holds across store and idle
    step("R7 store holds", 1, 1, 24, 3, 64'h1);
    idle("R7 idle holds");
    // R8: top word addressing
    step("R8 top store", 1, 1, NBYTES - 2, 1, 64'hBEEF);
    step("R8 top load", 1, 0, NBYTES - 8, 3, 64'd0);
    // R6: reset forgets contents
    doReset();
    step("R6 cleared after reset", 1, 0, 8, 3, 64'd0);

    // mixed traffic over a small window
    for (int k = 0; k < 600; k++) begin
      int a;
      int c;
      logic v;
      logic w;
      a = int'($urandom % 32);
      c = int'($urandom % 4);
      v = ($urandom % 8) != 0;
      w = ($urandom % 2) != 0;
      step("R3 R4 R5 mixed", v, w, a, c, {$urandom, $urandom});
    end

    summary();
  end

endmodule